// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit performs the clamping arithmetic used by a processor's DSP-style integer operations. Each operation works on 32-bit operands. The operations are signed and unsigned add and subtract, a signed doubling, and saturation of a value to a programmable bit width. The width saturation has a whole-word form and a form that treats the word as two independent 16-bit halves. A 4-bit opcode selects the operation. The result appears in a register one cycle after a valid strobe.

Alongside the result, the unit keeps one sticky saturation flag that every operation shares. Any valid operation whose result had to be clamped sets the flag. A plain add sets it on signed overflow but returns the wrapped sum. Once set, the flag stays set until a dedicated clear input or reset lowers it. The surrounding pipeline reads this flag to learn whether anything in a sequence of operations saturated.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcode 0 (signed add) returns A+B. If A and B have the same sign and the sum's sign differs from A, the result is 0x7FFFFFFF when A is non-negative and 0x80000000 when A is negative, and the operation clamps.
- R2: Opcode 1 (signed subtract) returns A-B. If A and B have different signs and the difference's sign differs from A, the result clamps the same way as R1, chosen by the sign of A.
- R3: Opcode 2 (flagging add) always returns the wrapped 32-bit A+B. It counts as clamping exactly when the signed sum overflows.
- R4: Opcode 3 (doubling) acts on A. A signed A at or above 0x40000000 gives 0x7FFFFFFF. A signed A at or below 0xC0000000 gives 0x80000000, and 0xC0000000 itself counts as clamping. Any other A gives A shifted left by one.
- R5: Opcode 4 (unsigned add) gives 0xFFFFFFFF when A+B exceeds 32 bits. Opcode 5 (unsigned subtract) gives 0 when B is greater than A. In both cases the operation clamps; otherwise the result is the plain sum or difference.
- R6: Opcode 6 (signed width saturate) clamps the signed A, with N = sat_width (0..31), into the range -2^N to 2^N-1. It counts as clamping when A lies outside that range.
- R7: Opcode 7 (unsigned width saturate) maps a negative A to 0 and an A above 2^N-1 to 2^N-1, and counts as clamping in both cases.
- R8: Opcodes 8 (signed) and 9 (unsigned) apply R6 and R7 separately to the sign-extended bits [15:0] and bits [31:16] of A. Each result is packed into the same half. The operation clamps if either half clamps.
- R9: result and res_valid are registered. The cycle after a cycle with op_valid high, res_valid is 1 and result holds that operation's value. res_valid is 0 after a cycle without op_valid.
- R10: q_flag is set by a valid operation that clamps. A valid operation that does not clamp leaves it unchanged, and it only rises after a cycle with op_valid high.
- R11: q_clear clears q_flag at the next clock edge. The clear takes priority over a clamping operation in the same cycle.
- R12: While rst_n is low at a clock edge, result, res_valid and q_flag become 0.
- R13: Opcodes 10 to 15 produce result 0 and leave q_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (see requirements) |
| opnd_a | input | 32 | First operand; the value to saturate for width operations |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Saturation width N for opcodes 6 to 9 |
| q_clear | input | 1 | Synchronous clear of the sticky flag |
| res_valid | output | 1 | Result register holds a new value |
| result | output | 32 | Registered operation result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with its default DATA_W of 32, which gives 16-bit halves and a 5-bit width field. With these values every width from 0 to 31 can be driven on both the word forms and the halfword forms. That includes widths 15 to 31, where a sign-extended half can never exceed the signed range, and negative halves under unsigned saturation, which clamp to zero at any width. Boundary operands around 2^N, the doubling thresholds and the signed extremes are driven for every opcode, and each result and the flag are compared with a behavioural model written in 64-bit arithmetic.

// File: rtl/sat_arith_pkg.sv
// Package: shared opcode encoding for the saturating arithmetic unit.
// Assumes a 4-bit opcode field; values 10..15 are unused.
package sat_arith_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_S    = 4'd0,
        OP_SUB_S    = 4'd1,
        OP_ADD_WRAP = 4'd2,
        OP_DBL      = 4'd3,
        OP_ADD_U    = 4'd4,
        OP_SUB_U    = 4'd5,
        OP_CLAMP_S  = 4'd6,
        OP_CLAMP_U  = 4'd7,
        OP_CLAMP_S2 = 4'd8,
        OP_CLAMP_U2 = 4'd9
    } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
// Module: sat_addsub
// Adds or subtracts two W-bit operands. Flags signed or unsigned overflow
// and, when clamp_en is high, replaces the wrapped value with the limit.
// Assumes the caller ignores ovf for operations that do not use it.
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_sub,
    input  logic         is_unsigned,
    input  logic         clamp_en,
    output logic [W-1:0] res,
    output logic         ovf
);

    logic [W:0]   ext_sum;
    logic [W-1:0] raw;
    logic         carry_out;
    logic         sign_same;
    logic         sign_moved;
    logic         s_ovf;
    logic [W-1:0] lim;

    // Wide add or subtract so the carry or borrow is available.
    always_comb begin
        if (is_sub) begin
            ext_sum = {1'b0, a} - {1'b0, b};
        end else begin
            ext_sum = {1'b0, a} + {1'b0, b};
        end
        raw       = ext_sum[W-1:0];
        carry_out = ext_sum[W];
    end

    // Signed overflow from operand and result signs.
    always_comb begin
        sign_same  = (a[W-1] == b[W-1]);
        sign_moved = (raw[W-1] != a[W-1]);
        s_ovf      = is_sub ? (!sign_same && sign_moved) : (sign_same && sign_moved);
    end

    // Pick the overflow kind and the limit value to clamp to.
    always_comb begin
        if (is_unsigned) begin
            ovf = carry_out;
            lim = is_sub ? '0 : '1;
        end else begin
            ovf = s_ovf;
            lim = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
        res = (ovf && clamp_en) ? lim : raw;
    end

endmodule

// File: rtl/sat_double.sv
// Module: sat_double
// Doubles a signed W-bit value. The thresholds are +/- 2^(W-2); the
// negative threshold itself counts as saturating. Assumes W >= 3.
module sat_double #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] res,
    output logic         hit
);

    logic too_high;
    logic too_low;

    // Compare against the thresholds using the top two bits and the rest.
    always_comb begin
        too_high = !x[W-1] && x[W-2];
        too_low  = x[W-1] && (!x[W-2] || (x[W-3:0] == '0));
        hit      = too_high || too_low;
        if (too_high) begin
            res = {1'b0, {(W-1){1'b1}}};
        end else if (too_low) begin
            res = {1'b1, {(W-1){1'b0}}};
        end else begin
            res = {x[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/sat_clamp.sv
// Module: sat_clamp
// Saturates a signed W-bit value to a width N (0..2^SH_W-1), either into
// the signed range [-2^N, 2^N-1] or into the unsigned range [0, 2^N-1].
// Uses mask tests rather than a shifter. Widths of W or more never clip a
// positive value.
module sat_clamp #(
    parameter int W    = 32,
    parameter int SH_W = 5
) (
    input  logic [W-1:0]    val_in,
    input  logic [SH_W-1:0] width_sel,
    input  logic            unsigned_mode,
    output logic [W-1:0]    val_out,
    output logic            clipped
);

    logic [W-1:0] keep_mask;
    logic [W-1:0] upper_mask;
    logic         above_max;
    logic         below_min;

    // Build the in-range mask for width N and its complement.
    always_comb begin
        keep_mask  = ~({W{1'b1}} << width_sel);
        upper_mask = ~keep_mask;
    end

    // Detect out-of-range from the bits at and above position N.
    always_comb begin
        above_max = !val_in[W-1] && (|(val_in & upper_mask));
        below_min = val_in[W-1] && !(&(val_in | keep_mask));
    end

    // Choose the clamped value for the selected mode.
    always_comb begin
        if (unsigned_mode) begin
            clipped = val_in[W-1] || above_max;
            if (val_in[W-1]) begin
                val_out = '0;
            end else if (above_max) begin
                val_out = keep_mask;
            end else begin
                val_out = val_in;
            end
        end else begin
            clipped = above_max || below_min;
            if (above_max) begin
                val_out = keep_mask;
            end else if (below_min) begin
                val_out = upper_mask;
            end else begin
                val_out = val_in;
            end
        end
    end

endmodule

// File: rtl/sat_arith_unit.sv
// Module: sat_arith_unit (top)
// Saturating arithmetic with a registered result and a sticky saturation
// flag. One operation per cycle when op_valid is high. Assumes DATA_W is
// even (two halves) and at least 8; the reset is synchronous and active-low.
module sat_arith_unit
    import sat_arith_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SH_W-1:0]   sat_width,
    input  logic              q_clear,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              q_flag
);

    localparam int LANES  = 2;
    localparam int HALF_W = DATA_W / LANES;

    sat_op_e                             op;
    logic                                as_sub;
    logic                                as_uns;
    logic                                as_clamp;
    logic                                cl_uns;
    logic [DATA_W-1:0]                   as_res;
    logic                                as_ovf;
    logic [DATA_W-1:0]                   dbl_res;
    logic                                dbl_hit;
    logic [DATA_W-1:0]                   word_res;
    logic                                word_hit;
    logic [LANES-1:0][HALF_W-1:0]        lane_res;
    logic [LANES-1:0]                    lane_hit;
    logic [DATA_W-1:0]                   nxt_res;
    logic                                nxt_hit;

    // Decode the opcode into the datapath controls.
    always_comb begin
        op       = sat_op_e'(op_code);
        as_sub   = (op == OP_SUB_S) || (op == OP_SUB_U);
        as_uns   = (op == OP_ADD_U) || (op == OP_SUB_U);
        as_clamp = (op != OP_ADD_WRAP);
        cl_uns   = (op == OP_CLAMP_U) || (op == OP_CLAMP_U2);
    end

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a           (opnd_a),
        .b           (opnd_b),
        .is_sub      (as_sub),
        .is_unsigned (as_uns),
        .clamp_en    (as_clamp),
        .res         (as_res),
        .ovf         (as_ovf)
    );

    sat_double #(.W(DATA_W)) u_double (
        .x   (opnd_a),
        .res (dbl_res),
        .hit (dbl_hit)
    );

    sat_clamp #(.W(DATA_W), .SH_W(SH_W)) u_word_clamp (
        .val_in        (opnd_a),
        .width_sel     (sat_width),
        .unsigned_mode (cl_uns),
        .val_out       (word_res),
        .clipped       (word_hit)
    );

    // One clamp per half for the dual-half forms.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.W(HALF_W), .SH_W(SH_W)) u_lane_clamp (
            .val_in        (opnd_a[g*HALF_W +: HALF_W]),
            .width_sel     (sat_width),
            .unsigned_mode (cl_uns),
            .val_out       (lane_res[g]),
            .clipped       (lane_hit[g])
        );
    end

    // Select the result and clamp indication of the chosen operation.
    always_comb begin
        case (op)
            OP_ADD_S, OP_SUB_S, OP_ADD_WRAP, OP_ADD_U, OP_SUB_U: begin
                nxt_res = as_res;
                nxt_hit = as_ovf;
            end
            OP_DBL: begin
                nxt_res = dbl_res;
                nxt_hit = dbl_hit;
            end
            OP_CLAMP_S, OP_CLAMP_U: begin
                nxt_res = word_res;
                nxt_hit = word_hit;
            end
            OP_CLAMP_S2, OP_CLAMP_U2: begin
                nxt_res = lane_res;
                nxt_hit = |lane_hit;
            end
            default: begin
                nxt_res = '0;
                nxt_hit = 1'b0;
            end
        endcase
    end

    // Capture the result for one cycle per valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                result <= nxt_res;
            end
        end
    end

    // Sticky flag: the clear wins over a set in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_flag <= 1'b0;
        end else if (q_clear) begin
            q_flag <= 1'b0;
        end else if (op_valid && nxt_hit) begin
            q_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/sat_arith_chk.sv
// Module: sat_arith_chk
// Checks the port-level timing and value relations of sat_arith_unit.
// Attached to every instance by the bind below.
module sat_arith_chk
    import sat_arith_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              q_clear,
    input logic              res_valid,
    input logic [DATA_W-1:0] result,
    input logic              q_flag
);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    assert_wrap_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADD_WRAP) |=> (result == $past(opnd_a + opnd_b)));

    assert_uadd_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADD_U) |=> (result >= $past(opnd_a)));

    assert_usub_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SUB_U) |=> (result <= $past(opnd_a)));

    assert_q_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag && !q_clear) |=> q_flag);

    assert_q_rise_needs_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_flag) |-> $past(op_valid));

    assert_q_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q_clear |=> !q_flag);

    assert_unused_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd10) |=> (result == '0));

    assert_unused_keeps_q_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd10 && !q_clear) |=> (q_flag == $past(q_flag)));

endmodule

bind sat_arith_unit sat_arith_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .q_clear   (q_clear),
    .res_valid (res_valid),
    .result    (result),
    .q_flag    (q_flag)
);

// File: tb/sat_arith_unit_tb.sv
// Bench: scoreboard for sat_arith_unit. The driver pushes expected values
// computed by a 64-bit behavioural model; the monitor pops and compares.
module sat_arith_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  sat_width = '0;
    logic        q_clear = 1'b0;
    logic        res_valid;
    logic [31:0] result;
    logic        q_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit qm = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        q;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    sat_arith_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .sat_width (sat_width),
        .q_clear   (q_clear),
        .res_valid (res_valid),
        .result    (result),
        .q_flag    (q_flag)
    );

    localparam longint MAXS = 64'sd2147483647;
    localparam longint MINS = -64'sd2147483648;

    function automatic logic [32:0] ref_ssat(longint v, int n);
        longint lim = longint'(1) << n;
        if (v > lim - 1) return {1'b1, 32'(lim - 1)};
        if (v < -lim)    return {1'b1, 32'(-lim)};
        return {1'b0, 32'(v)};
    endfunction

    function automatic logic [32:0] ref_usat(longint v, int n);
        longint lim = longint'(1) << n;
        if (v < 0)       return {1'b1, 32'd0};
        if (v > lim - 1) return {1'b1, 32'(lim - 1)};
        return {1'b0, 32'(v)};
    endfunction

    function automatic logic [32:0] ref_op(int op, logic [31:0] a, logic [31:0] b, int n);
        longint sa = longint'($signed(a));
        longint sb2 = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint t;
        logic [32:0] lo, hi;
        case (op)
            0, 1: begin
                t = (op == 0) ? sa + sb2 : sa - sb2;
                if (t > MAXS) return {1'b1, 32'h7FFF_FFFF};
                if (t < MINS) return {1'b1, 32'h8000_0000};
                return {1'b0, 32'(t)};
            end
            2: begin
                t = sa + sb2;
                return {(t > MAXS) || (t < MINS), 32'(a + b)};
            end
            3: begin
                if (sa >= (longint'(1) << 30))  return {1'b1, 32'h7FFF_FFFF};
                if (sa <= -(longint'(1) << 30)) return {1'b1, 32'h8000_0000};
                return {1'b0, 32'(sa * 2)};
            end
            4: begin
                t = ua + ub;
                if (t > 64'sd4294967295) return {1'b1, 32'hFFFF_FFFF};
                return {1'b0, 32'(t)};
            end
            5: begin
                if (ub > ua) return {1'b1, 32'd0};
                return {1'b0, 32'(ua - ub)};
            end
            6: return ref_ssat(sa, n);
            7: return ref_usat(sa, n);
            8, 9: begin
                if (op == 8) begin
                    lo = ref_ssat(longint'($signed(a[15:0])), n);
                    hi = ref_ssat(longint'($signed(a[31:16])), n);
                end else begin
                    lo = ref_usat(longint'($signed(a[15:0])), n);
                    hi = ref_usat(longint'($signed(a[31:16])), n);
                end
                return {lo[32] | hi[32], hi[15:0], lo[15:0]};
            end
            default: return 33'd0;
        endcase
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5: return "R5";
            6: return "R6";
            7: return "R7";
            8, 9: return "R8";
            default: return "R13";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation and record its expected result and flag.
    task automatic drive(int op, logic [31:0] a, logic [31:0] b, int n, bit clr, string tag);
        logic [32:0] r;
        exp_t e;
        @(negedge clk);
        op_valid  = 1'b1;
        op_code   = 4'(op);
        opnd_a    = a;
        opnd_b    = b;
        sat_width = 5'(n);
        q_clear   = clr;
        r = ref_op(op, a, b, n);
        qm = clr ? 1'b0 : (qm | r[32]);
        e.res = r[31:0];
        e.q   = qm;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            q_clear  = 1'b0;
        end
    endtask

    // Clear the flag with no operation, then confirm it is low (R11).
    task automatic clear_q();
        @(negedge clk);
        op_valid = 1'b0;
        q_clear  = 1'b1;
        qm = 1'b0;
        @(negedge clk);
        q_clear = 1'b0;
        check("R11 clear", {31'd0, q_flag}, 32'd0);
    endtask

    // Monitor: compare each produced result against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check("R9 unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " result"}, result, e.res);
                check({e.tag, " R10 q_flag"}, {31'd0, q_flag}, {31'd0, e.q});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] EDGES [10] = '{
        32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
        32'h4000_0000, 32'h3FFF_FFFF, 32'hC000_0000, 32'hC000_0001, 32'hBFFF_FFFF
    };

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 result", result, 32'd0);
        check("R12 res_valid", {31'd0, res_valid}, 32'd0);
        check("R12 q_flag", {31'd0, q_flag}, 32'd0);
        rst_n = 1'b1;

        // Directed corner cases
        drive(0, 32'h7FFF_FFFF, 32'h1, 0, 1'b0, "R1 pos clamp");
        drive(0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1'b0, "R1 neg clamp");
        drive(1, 32'h8000_0000, 32'h1, 0, 1'b0, "R2 neg clamp");
        drive(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0, "R2 pos clamp");
        idle(2);
        clear_q();
        drive(0, 32'd5, 32'hFFFF_FFFD, 0, 1'b0, "R10 no clamp keeps q low");
        drive(2, 32'h7FFF_FFFF, 32'h1, 0, 1'b0, "R3 wrap");
        drive(3, 32'h3FFF_FFFF, 32'h0, 0, 1'b0, "R4 below top");
        drive(3, 32'hC000_0000, 32'h0, 0, 1'b0, "R4 bottom threshold");
        drive(3, 32'hC000_0001, 32'h0, 0, 1'b0, "R4 above bottom");
        drive(4, 32'hFFFF_FFF0, 32'h10, 0, 1'b0, "R5 uadd clamp");
        drive(5, 32'h5, 32'h6, 0, 1'b0, "R5 usub clamp");
        drive(6, 32'h0000_0100, 32'h0, 8, 1'b0, "R6 width 8 high");
        drive(6, 32'hFFFF_FEFF, 32'h0, 8, 1'b0, "R6 width 8 low");
        drive(7, 32'hFFFF_FFFF, 32'h0, 4, 1'b0, "R7 negative");
        drive(8, 32'h8000_7FFF, 32'h0, 3, 1'b0, "R8 both halves");
        drive(9, 32'h0005_FFFE, 32'h0, 20, 1'b0, "R8 neg low half");
        drive(0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1'b1, "R11 clear beats set");
        drive(12, 32'h7FFF_FFFF, 32'h1, 3, 1'b0, "R13 unused op");
        drive(15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 31, 1'b0, "R13 unused op");
        idle(2);

        // Boundary operand pairs for the arithmetic operations
        for (int op = 0; op < 6; op++) begin
            clear_q();
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    drive(op, EDGES[i], EDGES[j], 0, 1'b0, tag_of(op));
                end
            end
            idle(2);
        end

        // Every width with values just inside and outside the range
        for (int op = 6; op < 10; op++) begin
            clear_q();
            for (int n = 0; n < 32; n++) begin
                logic [31:0] p = 32'(longint'(1) << n);
                logic [15:0] h = 16'(p);
                drive(op, p - 1, 32'h0, n, 1'b0, tag_of(op));
                drive(op, p, 32'h0, n, 1'b0, tag_of(op));
                drive(op, -p, 32'h0, n, 1'b0, tag_of(op));
                drive(op, -p - 1, 32'h0, n, 1'b0, tag_of(op));
                drive(op, {h, 16'(h - 16'd1)}, 32'h0, n, 1'b0, tag_of(op));
                drive(op, {16'(-h - 16'd1), 16'(-h)}, 32'h0, n, 1'b0, tag_of(op));
                drive(op, 32'h7FFF_8000, 32'h0, n, 1'b0, tag_of(op));
            end
            idle(2);
        end

        // Random operands for every opcode, flag cleared now and then
        for (int k = 0; k < 4000; k++) begin
            int op = int'($urandom_range(0, 15));
            drive(op, $urandom, $urandom, int'($urandom_range(0, 31)),
                  ($urandom_range(0, 15) == 0), tag_of(op));
        end
        idle(3);

        check("R9 scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule